// File: doc/BRIEF.md
# Transactional Cache Line Conflict Tracker

This block holds the tag and coherence state array of a small set-associative first-level data cache that supports hardware transactions. Each line carries a four-state coherence code and a transactional mark. While a transaction is open, local loads add their line to the read set, and local stores add their line to the write set. A line is in the write set when it is marked and Modified. Snooped reads and writes from other agents are checked against these sets at the granularity of a whole line. A conflict aborts the local transaction. A commit clears every mark in one cycle. An abort invalidates every marked Modified line and then clears every mark.

Local requests use a valid/ready handshake. A snoop always takes the lookup port for its cycle, so `req_ready` is low whenever `snp_valid` is high. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. The requester must hold its request until that cycle. Snoops have no back-pressure and are processed in the cycle they are presented. Transaction begin and commit are plain single-cycle strobes. Every result appears on registered outputs one clock after the operation that caused it. Data storage, bus timing and the replacement policy beyond victim choice are outside this block. The block does report evictions.

Top module: `tmc_tracker`

## Requirements
- R1: After reset every line is Invalid with its mark clear and `in_tx` is 0. Every pulse output is 0. A first load to any address misses with `rsp_state` 0.
- R2: `req_ready` equals the inverse of `snp_valid`. A request is accepted only when `req_valid` and `req_ready` are both high. One cycle later `rsp_valid` pulses with `rsp_hit`. `rsp_state` gives the line's state before the access, encoded I=0, S=1, E=2, M=3, and reads 0 on a miss.
- R3: A load miss fills the line as E. A store, whether it hits or misses, leaves the line M. Any access accepted while `in_tx` is 1 marks its line.
- R4: While a transaction is open, a snooped read that hits a marked M line raises `abort_valid` one cycle later with `abort_cause` 1 (conflict). In that case `snp_supply` stays 0.
- R5: While a transaction is open, a snooped write that hits any marked line raises a conflict abort (cause 1). The snooped line ends Invalid.
- R6: A snooped read that hits an unmarked line moves it to S. It raises `snp_supply` when the line was M. A snooped write that hits an unmarked line moves it to I. Neither case aborts.
- R7: `tx_begin` sets `in_tx` on the next cycle. `tx_commit` clears every mark and `in_tx`, and M lines stay M. Commit takes precedence over begin. An abort in the same cycle takes precedence over both.
- R8: On any abort, every marked M line becomes I. Unmarked lines and marked lines in other states keep their state. All marks clear and `in_tx` falls in the same cycle as the `abort_valid` pulse.
- R9: Inside a transaction, a store that hits an unmarked M line pulses `wb_valid` one cycle later, so the old data is written back before it is overwritten.
- R10: On a miss the victim is the lowest-numbered Invalid way. If there is none, it is the lowest way not in the write set. If every way holds a write-set line, the request causes an abort with `abort_cause` 2 (overflow) and fills nothing. So a ninth distinct transactional store into one set of an eight-way cache always aborts.
- R11: Replacing a valid victim pulses `ev_valid`, with `ev_dirty` set when the victim was M. Evicting a read-set-only line drops its mark and does not abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the open transaction |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Local request can be accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_set | input | SET_W | Set index of the local access |
| req_tag | input | TAG_W | Tag of the local access |
| snp_valid | input | 1 | Snooped remote access present |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_set | input | SET_W | Set index of the snoop |
| snp_tag | input | TAG_W | Tag of the snoop |
| rsp_valid | output | 1 | Result of an accepted request |
| rsp_hit | output | 1 | Request hit a valid line |
| rsp_state | output | 2 | State before the access (I=0,S=1,E=2,M=3) |
| snp_done | output | 1 | Result of a snoop |
| snp_hit | output | 1 | Snoop hit a valid line |
| snp_supply | output | 1 | Local cache supplies dirty data for the snoop |
| wb_valid | output | 1 | Write back an unmarked M line before its first transactional store |
| ev_valid | output | 1 | A valid victim was replaced |
| ev_dirty | output | 1 | Replaced victim was M |
| abort_valid | output | 1 | Transaction aborted |
| abort_cause | output | 2 | 0 none, 1 conflict, 2 overflow |
| in_tx | output | 1 | Transaction open |

## Verification
A wrong mark or state inside the array does not show up in the cycle it goes wrong. It shows up on the next access to that line. A lost mark hides a conflict, so a snoop that should abort instead returns `snp_done` with no `abort_valid`. A stale mark aborts a later transaction without reason. A line left valid after an abort returns a hit, or `rsp_state` 3, where a miss was due. The bench therefore follows every transaction end with snoops and loads to the lines involved. It compares every output one cycle after each operation, so any divergence is reported on the first access that exposes it.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    AB_NONE     = 2'd0,
    AB_CONFLICT = 2'd1,
    AB_OVERFLOW = 2'd2
  } abort_cause_e;
endpackage

// File: rtl/tmc_lookup.sv
module tmc_lookup
  import tmc_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0][1:0]       states,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  // Lowest matching way wins; descending scan leaves it last-assigned.
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (states[w] != ST_I && tags[w] == key) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/tmc_victim.sv
module tmc_victim
  import tmc_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][1:0] states,
  input  logic [WAYS-1:0]      marks,
  output logic [WAY_W-1:0]     way,
  output logic                 in_wset
);
  logic             inv_found, free_found;
  logic [WAY_W-1:0] inv_way, free_way;

  always_comb begin
    inv_found  = 1'b0;
    free_found = 1'b0;
    inv_way    = '0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (states[w] == ST_I) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
      if (!(marks[w] && states[w] == ST_M)) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
    if (inv_found) begin
      way     = inv_way;
      in_wset = 1'b0;
    end else if (free_found) begin
      way     = free_way;
      in_wset = 1'b0;
    end else begin
      way     = '0;
      in_wset = 1'b1;
    end
  end
endmodule

// File: rtl/tmc_tracker.sv
module tmc_tracker
  import tmc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 8,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_begin,
  input  logic             tx_commit,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [SET_W-1:0] snp_set,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_state,
  output logic             snp_done,
  output logic             snp_hit,
  output logic             snp_supply,
  output logic             wb_valid,
  output logic             ev_valid,
  output logic             ev_dirty,
  output logic             abort_valid,
  output logic [1:0]       abort_cause,
  output logic             in_tx
);
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [SETS-1:0][WAYS-1:0][1:0]       st_q, st_d;
  logic [SETS-1:0][WAYS-1:0]            t_q, t_d;
  logic                                 in_tx_q, in_tx_d;

  logic             r_hit, s_hit, v_wset;
  logic [WAY_W-1:0] r_way, s_way, v_way;
  logic             req_fire;

  logic             abort_n, wb_n, ev_n, evd_n, supply_n;
  logic [1:0]       cause_n;
  logic [1:0]       rstate_n;

  assign req_ready = !snp_valid;
  assign req_fire  = req_valid && req_ready;

  tmc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_lookup (
    .tags(tag_q[req_set]), .states(st_q[req_set]), .key(req_tag),
    .hit(r_hit), .way(r_way)
  );

  tmc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_lookup (
    .tags(tag_q[snp_set]), .states(st_q[snp_set]), .key(snp_tag),
    .hit(s_hit), .way(s_way)
  );

  tmc_victim #(.WAYS(WAYS)) u_victim (
    .states(st_q[req_set]), .marks(t_q[req_set]),
    .way(v_way), .in_wset(v_wset)
  );

  always_comb begin
    tag_d    = tag_q;
    st_d     = st_q;
    t_d      = t_q;
    in_tx_d  = in_tx_q;
    abort_n  = 1'b0;
    cause_n  = AB_NONE;
    wb_n     = 1'b0;
    ev_n     = 1'b0;
    evd_n    = 1'b0;
    supply_n = 1'b0;
    rstate_n = ST_I;

    if (snp_valid) begin
      if (s_hit) begin
        // Remote write conflicts with any mark; remote read only with write set.
        if (in_tx_q && (snp_write ? t_q[snp_set][s_way]
                                  : (t_q[snp_set][s_way] && st_q[snp_set][s_way] == ST_M))) begin
          abort_n = 1'b1;
          cause_n = AB_CONFLICT;
        end
        if (snp_write) begin
          st_d[snp_set][s_way] = ST_I;
          t_d[snp_set][s_way]  = 1'b0;
        end else if (!abort_n) begin
          supply_n             = (st_q[snp_set][s_way] == ST_M);
          st_d[snp_set][s_way] = ST_S;
        end
      end
    end else if (req_fire) begin
      if (r_hit) begin
        rstate_n = st_q[req_set][r_way];
        if (req_write) begin
          wb_n = in_tx_q && st_q[req_set][r_way] == ST_M && !t_q[req_set][r_way];
          st_d[req_set][r_way] = ST_M;
        end
        if (in_tx_q) t_d[req_set][r_way] = 1'b1;
      end else if (v_wset && in_tx_q) begin
        abort_n = 1'b1;
        cause_n = AB_OVERFLOW;
      end else begin
        ev_n  = (st_q[req_set][v_way] != ST_I);
        evd_n = (st_q[req_set][v_way] == ST_M);
        tag_d[req_set][v_way] = req_tag;
        st_d[req_set][v_way]  = req_write ? ST_M : ST_E;
        t_d[req_set][v_way]   = in_tx_q;
      end
    end

    if (abort_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (t_q[s][w] && st_q[s][w] == ST_M) st_d[s][w] = ST_I;
        end
      end
      t_d     = '0;
      in_tx_d = 1'b0;
    end else if (tx_commit) begin
      t_d     = '0;
      in_tx_d = 1'b0;
    end else if (tx_begin) begin
      in_tx_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q       <= '0;
      st_q        <= '0;
      t_q         <= '0;
      in_tx_q     <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_state   <= '0;
      snp_done    <= 1'b0;
      snp_hit     <= 1'b0;
      snp_supply  <= 1'b0;
      wb_valid    <= 1'b0;
      ev_valid    <= 1'b0;
      ev_dirty    <= 1'b0;
      abort_valid <= 1'b0;
      abort_cause <= '0;
    end else begin
      tag_q       <= tag_d;
      st_q        <= st_d;
      t_q         <= t_d;
      in_tx_q     <= in_tx_d;
      rsp_valid   <= req_fire;
      rsp_hit     <= req_fire && r_hit;
      rsp_state   <= rstate_n;
      snp_done    <= snp_valid;
      snp_hit     <= snp_valid && s_hit;
      snp_supply  <= supply_n;
      wb_valid    <= wb_n;
      ev_valid    <= ev_n;
      ev_dirty    <= evd_n;
      abort_valid <= abort_n;
      abort_cause <= cause_n;
    end
  end

  assign in_tx = in_tx_q;
endmodule

// File: rtl/tmc_tracker_chk.sv
module tmc_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       snp_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       snp_done,
  input logic       snp_supply,
  input logic       wb_valid,
  input logic       ev_dirty,
  input logic       ev_valid,
  input logic       abort_valid,
  input logic [1:0] abort_cause,
  input logic       in_tx
);
  // R2: snoop holds the lookup port
  a_r2_snoop_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready);

  // R2: one operation result per cycle
  a_r2_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, snp_done}));

  // R4: no data supplied on a conflicting read
  a_r4_no_supply_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> !abort_valid);

  // R8: an abort needs an open transaction and closes it
  a_r8_abort_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> $past(in_tx));

  a_r8_abort_closes_tx: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> !in_tx);

  // R10: cause is coded only with an abort
  a_r10_cause_coded: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> (abort_cause == 2'd1 || abort_cause == 2'd2));

  a_r10_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_valid |-> abort_cause == 2'd0);

  // R9: write-back only for a store inside a transaction
  a_r9_wb_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(in_tx));

  // R11: dirty flag only with an eviction
  a_r11_dirty_with_evict: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dirty |-> ev_valid);
endmodule

bind tmc_tracker tmc_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .snp_done(snp_done), .snp_supply(snp_supply),
  .wb_valid(wb_valid), .ev_dirty(ev_dirty), .ev_valid(ev_valid),
  .abort_valid(abort_valid), .abort_cause(abort_cause), .in_tx(in_tx)
);

// File: tb/tb_tmc_tracker.sv
module tb_tmc_tracker;
  localparam int SETS = 4, WAYS = 8, TAG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_begin = 0, tx_commit = 0;
  logic req_valid = 0, req_write = 0, snp_valid = 0, snp_write = 0;
  logic [1:0] req_set = '0, snp_set = '0;
  logic [TAG_W-1:0] req_tag = '0, snp_tag = '0;
  logic req_ready, rsp_valid, rsp_hit, snp_done, snp_hit, snp_supply;
  logic wb_valid, ev_valid, ev_dirty, abort_valid, in_tx;
  logic [1:0] rsp_state, abort_cause;

  always #5 clk = ~clk;

  tmc_tracker #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // Behavioural reference: state 0=I 1=S 2=E 3=M
  int m_tag [SETS][WAYS];
  int m_st  [SETS][WAYS];
  bit m_t   [SETS][WAYS];
  bit m_intx;
  bit e_rv, e_rh, e_sd, e_sh, e_sup, e_wb, e_ev, e_evd, e_ab;
  int e_rs, e_cause;
  string cur = "R1";

  function automatic int find(int s, int tg);
    for (int w = 0; w < WAYS; w++) if (m_st[s][w] != 0 && m_tag[s][w] == tg) return w;
    return -1;
  endfunction

  function automatic void flash_abort();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        if (m_t[s][w] && m_st[s][w] == 3) m_st[s][w] = 0;
        m_t[s][w] = 0;
      end
    m_intx = 0;
  endfunction

  function automatic void model(bit rv, bit rw, int rs, int rt, bit sv, bit sw, int ss, int st, bit b, bit c);
    int h, v;
    {e_rv, e_rh, e_sd, e_sh, e_sup, e_wb, e_ev, e_evd, e_ab} = '0;
    e_rs = 0; e_cause = 0;
    if (sv) begin
      e_sd = 1;
      h = find(ss, st);
      if (h >= 0) begin
        e_sh = 1;
        if (m_intx && (sw ? m_t[ss][h] : (m_t[ss][h] && m_st[ss][h] == 3))) begin
          e_ab = 1; e_cause = 1;
        end
        if (e_ab) flash_abort();
        if (sw) begin m_st[ss][h] = 0; m_t[ss][h] = 0; end
        else if (!e_ab) begin e_sup = (m_st[ss][h] == 3); m_st[ss][h] = 1; end
      end
    end else if (rv) begin
      e_rv = 1;
      h = find(rs, rt);
      if (h >= 0) begin
        e_rh = 1; e_rs = m_st[rs][h];
        if (rw) begin
          e_wb = m_intx && m_st[rs][h] == 3 && !m_t[rs][h];
          m_st[rs][h] = 3;
        end
        if (m_intx) m_t[rs][h] = 1;
      end else begin
        v = -1;
        for (int w = 0; w < WAYS && v < 0; w++) if (m_st[rs][w] == 0) v = w;
        for (int w = 0; w < WAYS && v < 0; w++) if (!(m_t[rs][w] && m_st[rs][w] == 3)) v = w;
        if (v < 0) begin
          e_ab = 1; e_cause = 2; flash_abort();
        end else begin
          e_ev = (m_st[rs][v] != 0); e_evd = (m_st[rs][v] == 3);
          m_tag[rs][v] = rt; m_st[rs][v] = rw ? 3 : 2; m_t[rs][v] = m_intx;
        end
      end
    end
    if (!e_ab) begin
      if (c) begin
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_t[s][w] = 0;
        m_intx = 0;
      end else if (b) m_intx = 1;
    end
  endfunction

  task automatic compare();
    tests++;
    if ({rsp_valid, rsp_hit, rsp_state, snp_done, snp_hit, snp_supply, wb_valid,
         ev_valid, ev_dirty, abort_valid, abort_cause, in_tx} !==
        {e_rv, e_rh, 2'(e_rs), e_sd, e_sh, e_sup, e_wb, e_ev, e_evd, e_ab, 2'(e_cause), m_intx}) begin
      fails++;
      $display("FAIL %s: got rv%b h%b st%0d sd%b sh%b sup%b wb%b ev%b evd%b ab%b c%0d tx%b expected rv%b h%b st%0d sd%b sh%b sup%b wb%b ev%b evd%b ab%b c%0d tx%b",
        cur, rsp_valid, rsp_hit, rsp_state, snp_done, snp_hit, snp_supply, wb_valid, ev_valid,
        ev_dirty, abort_valid, abort_cause, in_tx, e_rv, e_rh, e_rs, e_sd, e_sh, e_sup, e_wb,
        e_ev, e_evd, e_ab, e_cause, m_intx);
    end
  endtask

  task automatic op(string tag, bit rv, bit rw, int rs, int rt,
                    bit sv = 0, bit sw = 0, int ss = 0, int st = 0, bit b = 0, bit c = 0);
    @(negedge clk);
    compare();
    cur = tag;
    req_valid = rv; req_write = rw; req_set = 2'(rs); req_tag = TAG_W'(rt);
    snp_valid = sv; snp_write = sw; snp_set = 2'(ss); snp_tag = TAG_W'(st);
    tx_begin = b; tx_commit = c;
    model(rv, rw, rs, rt, sv, sw, ss, st, b, c);
    #1;
    tests++;
    if (req_ready !== !sv) begin
      fails++;
      $display("FAIL R2: req_ready got %b expected %b", req_ready, !sv);
    end
  endtask

  task automatic idle(string tag);            op(tag, 0, 0, 0, 0); endtask
  task automatic ld(string tag, int s, int t); op(tag, 1, 0, s, t); endtask
  task automatic stw(string tag, int s, int t); op(tag, 1, 1, s, t); endtask
  task automatic sr(string tag, int s, int t); op(tag, 0, 0, 0, 0, 1, 0, s, t); endtask
  task automatic sw(string tag, int s, int t); op(tag, 0, 0, 0, 0, 1, 1, s, t); endtask
  task automatic beg(string tag);             op(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
  task automatic cmt(string tag);             op(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_tag[s][w] = 0; m_st[s][w] = 0; m_t[s][w] = 0; end
    m_intx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: quiet after reset, first load misses
    idle("R1"); ld("R1", 0, 10);
    // R3: fills and hits
    ld("R3", 0, 10); stw("R3", 0, 11); stw("R3", 0, 11);
    // R6: unmarked snoops
    sr("R6", 0, 10); sr("R6", 0, 11); ld("R6", 0, 11);
    stw("R6", 0, 12); sw("R6", 0, 12); ld("R6", 0, 12); sr("R6", 1, 99);
    // R9: write-back before first transactional store
    stw("R9", 0, 13); beg("R7"); stw("R9", 0, 13); stw("R9", 0, 13);
    // R4/R8: remote read of write set aborts
    stw("R4", 1, 20); ld("R3", 1, 21); sr("R4", 1, 20);
    ld("R8", 1, 20); ld("R8", 0, 13); ld("R8", 1, 21); ld("R8", 0, 10);
    // R5: remote write of read-set line aborts and invalidates
    beg("R7"); ld("R5", 2, 30); sw("R5", 2, 30); ld("R5", 2, 30);
    // R5: read-set line is not a conflict for a remote read
    beg("R7"); ld("R5", 2, 31); sr("R5", 2, 31); cmt("R7");
    // R7: commit keeps M lines visible
    beg("R7"); stw("R7", 3, 40); ld("R7", 3, 41); cmt("R7");
    sr("R7", 3, 40); sw("R7", 3, 41); ld("R7", 3, 40);
    // R7: begin and commit together, commit wins
    op("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1); idle("R7");
    // R7: conflict abort wins over commit in same cycle
    beg("R7"); stw("R7", 1, 50); op("R7", 0, 0, 0, 0, 1, 0, 1, 50, 0, 1); ld("R7", 1, 50);
    // R2: request held while a snoop owns the port
    op("R2", 1, 1, 2, 60, 1, 0, 2, 30); op("R2", 1, 1, 2, 60); ld("R2", 2, 60);
    // R10: ninth transactional store into one set overflows
    beg("R10");
    for (int i = 0; i < 8; i++) stw("R10", 3, 100 + i);
    stw("R10", 3, 108);
    for (int i = 0; i < 9; i++) ld("R10", 3, 100 + i);
    // R10: victim prefers non-write-set line inside a transaction
    beg("R10"); stw("R10", 3, 120); ld("R10", 3, 121);
    cmt("R10");
    // R11: dirty eviction outside a transaction
    for (int i = 0; i < 8; i++) stw("R11", 2, 70 + i);
    ld("R11", 2, 80); ld("R11", 2, 70);
    // R11: evicting read-set lines does not abort
    beg("R11");
    for (int i = 0; i < 9; i++) ld("R11", 2, 90 + i);
    sr("R11", 2, 98); cmt("R11");
    idle("R11"); idle("R11");
    @(negedge clk); compare();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule